// File: doc/BRIEF.md
# Debounced Motion Wake-Up Detector

This block watches a stream of signed tri-axis acceleration samples, each marked by a one-cycle strobe. Samples arrive at whatever detection rate the surrounding logic sets. Each sample is scaled down to quarter-g units by an arithmetic right shift. Each of the six signed directions is then compared against a programmed magnitude threshold. A direction counts only if its bit in the direction mask is set.

When at least one unmasked direction stays beyond the threshold for a programmed number of consecutive strobed samples, the block does three things:
- It emits a one-cycle wake pulse.
- It sets a pending flag, which stays set until a release strobe clears it.
- It latches which directions caused the event.

After firing, the detector stays quiet until motion falls back inside the threshold at least once. A sustained shake therefore produces a single event. The persistence count sets the debounce time: count = delay × detection rate, so 5 samples at 50 Hz is 0.1 s. The threshold has a resolution of 4 counts per g, so a value of 2 means 0.5 g.

Top module: `motion_wake_detector`

## Requirements
- R1: After reset, wake_pulse_o, wake_pending_o and dir_status_o are all zero.
- R2: Each axis sample is arithmetically shifted right by SCALE_SHIFT (default 10). The result is rounded toward minus infinity. The positive direction of that axis is exceeded when the result is >= thresh_i. The negative direction is exceeded when the result is <= -thresh_i.
- R3: The direction mask bits are: bit5 x-, bit4 x+, bit3 y-, bit2 y+, bit1 z-, bit0 z+. Directions whose bit is clear never qualify a sample. dir_status_o uses the same layout.
- R4: The event fires on the count_i-th consecutive qualifying strobed sample, and a count_i of 0 acts as 1. wake_pulse_o is high for exactly the one cycle that follows that strobe.
- R5: A strobed sample with no unmasked direction exceeded clears the persistence count.
- R6: Cycles without sample_valid_i neither advance nor clear the persistence count.
- R7: On firing, dir_status_o loads the set of unmasked exceeded directions of the firing sample. It holds that value until the next firing, including across a release.
- R8: A firing sets wake_pending_o. release_i clears it on the next edge. A firing in the same cycle as release_i leaves it set.
- R9: After a firing, qualifying samples raise no further event until a non-qualifying sample has been seen. Counting then restarts from zero.
- R10: While enable_i or run_i is low, samples are ignored, the persistence count is cleared and the detector is re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Detector enable |
| run_i | input | 1 | Sensor in operating mode |
| sample_valid_i | input | 1 | One-cycle strobe marking a new sample |
| x_i | input | SAMPLE_W | Signed X sample |
| y_i | input | SAMPLE_W | Signed Y sample |
| z_i | input | SAMPLE_W | Signed Z sample |
| dir_mask_i | input | 6 | Direction enable mask |
| thresh_i | input | THR_W | Threshold in quarter-g units |
| count_i | input | CNT_W | Required consecutive qualifying samples |
| release_i | input | 1 | Clears the pending flag |
| wake_pulse_o | output | 1 | One-cycle event pulse |
| wake_pending_o | output | 1 | Event pending until released |
| dir_status_o | output | 6 | Directions that caused the last event |

## Verification
The bench drives samples just above and just below the threshold on both signs. One case is a negative value that truncates differently from floor division, which a design that divides instead of shifting would miss.

It interleaves misses and idle cycles within a debounce run:
- A counter that ignores misses would fire early.
- A counter that counts clock cycles instead of strobes would fire early.
- A counter that clears on idle cycles would fire late.

It holds motion after an event to catch a detector that re-fires without rearming. It toggles the operating-mode input partway through a count, which exposes a stale count surviving the drop. It collides a release with a firing sample, where a wrong priority loses the new event.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int NUM_AXIS = 3;
  localparam int NUM_DIR  = 2 * NUM_AXIS;
  // axis index: 0 = z, 1 = y, 2 = x; direction bit 2a is +, 2a+1 is -
  localparam int AX_Z = 0;
  localparam int AX_Y = 1;
  localparam int AX_X = 2;
  typedef logic [NUM_DIR-1:0] dir_vec_t;
endpackage

// File: rtl/mwd_dir_compare.sv
module mwd_dir_compare #(
  parameter int SAMPLE_W    = 16,
  parameter int THR_W       = 8,
  parameter int SCALE_SHIFT = 10
) (
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic        [THR_W-1:0]    thresh_i,
  output logic                       pos_o,
  output logic                       neg_o
);
  localparam int CMP_W = SAMPLE_W + 1;

  logic signed [SAMPLE_W-1:0] shifted;
  logic signed [CMP_W-1:0]    scaled;
  logic signed [CMP_W-1:0]    lim_pos;
  logic signed [CMP_W-1:0]    lim_neg;

  always_comb begin
    shifted = sample_i >>> SCALE_SHIFT;
    scaled  = {shifted[SAMPLE_W-1], shifted};
    lim_pos = $signed({{(CMP_W-THR_W){1'b0}}, thresh_i});
    lim_neg = -lim_pos;
    pos_o   = (scaled >= lim_pos);
    neg_o   = (scaled <= lim_neg);
  end
endmodule

// File: rtl/mwd_persist.sv
module mwd_persist #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             strobe_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   goal;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    goal    = (count_i == '0) ? (CNT_W+1)'(1) : {1'b0, count_i};
    fire_o  = active_i && strobe_i && hit_i && armed_q && (cnt_inc >= goal);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (!active_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (strobe_i) begin
      if (!hit_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (fire_o) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else if (armed_q) begin
        cnt_q   <= cnt_inc[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mwd_event.sv
module mwd_event
  import mwd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     fire_i,
  input  dir_vec_t cause_i,
  input  logic     release_i,
  output logic     pulse_o,
  output logic     pending_o,
  output dir_vec_t status_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_o   <= 1'b0;
      pending_o <= 1'b0;
      status_o  <= '0;
    end else begin
      pulse_o <= fire_i;
      if (fire_i) begin
        pending_o <= 1'b1;
        status_o  <= cause_i;
      end else if (release_i) begin
        pending_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/motion_wake_detector.sv
module motion_wake_detector
  import mwd_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int THR_W       = 8,
  parameter int CNT_W       = 8,
  parameter int SCALE_SHIFT = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       enable_i,
  input  logic                       run_i,
  input  logic                       sample_valid_i,
  input  logic signed [SAMPLE_W-1:0] x_i,
  input  logic signed [SAMPLE_W-1:0] y_i,
  input  logic signed [SAMPLE_W-1:0] z_i,
  input  logic [NUM_DIR-1:0]         dir_mask_i,
  input  logic [THR_W-1:0]           thresh_i,
  input  logic [CNT_W-1:0]           count_i,
  input  logic                       release_i,
  output logic                       wake_pulse_o,
  output logic                       wake_pending_o,
  output logic [NUM_DIR-1:0]         dir_status_o
);
  logic signed [SAMPLE_W-1:0] axis_s [NUM_AXIS];
  dir_vec_t exceed;
  dir_vec_t cause;
  logic     hit;
  logic     active;
  logic     fire;

  assign axis_s[AX_Z] = z_i;
  assign axis_s[AX_Y] = y_i;
  assign axis_s[AX_X] = x_i;

  for (genvar a = 0; a < NUM_AXIS; a++) begin : g_axis
    mwd_dir_compare #(
      .SAMPLE_W   (SAMPLE_W),
      .THR_W      (THR_W),
      .SCALE_SHIFT(SCALE_SHIFT)
    ) i_cmp (
      .sample_i(axis_s[a]),
      .thresh_i(thresh_i),
      .pos_o   (exceed[2*a]),
      .neg_o   (exceed[2*a+1])
    );
  end

  assign cause  = exceed & dir_mask_i;
  assign hit    = |cause;
  assign active = enable_i & run_i;

  mwd_persist #(.CNT_W(CNT_W)) i_persist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .strobe_i(sample_valid_i),
    .hit_i   (hit),
    .count_i (count_i),
    .fire_o  (fire)
  );

  mwd_event i_event (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .cause_i  (cause),
    .release_i(release_i),
    .pulse_o  (wake_pulse_o),
    .pending_o(wake_pending_o),
    .status_o (dir_status_o)
  );
endmodule

// File: rtl/mwd_checker.sv
module mwd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic       run_i,
  input logic       sample_valid_i,
  input logic [5:0] dir_mask_i,
  input logic       release_i,
  input logic       wake_pulse_o,
  input logic       wake_pending_o,
  input logic [5:0] dir_status_o
);
  p_pulse_one_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |=> !wake_pulse_o);

  p_pulse_from_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |-> $past(sample_valid_i));

  p_inactive_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(enable_i && run_i) |=> !wake_pulse_o);

  p_pending_with_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |-> wake_pending_o);

  p_pending_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_pending_o) |-> wake_pulse_o);

  p_release_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> (wake_pulse_o || !wake_pending_o));

  p_status_changes_on_fire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dir_status_o) |-> wake_pulse_o);

  p_status_in_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |-> ((dir_status_o != 6'd0) && ((dir_status_o & ~$past(dir_mask_i)) == 6'd0)));
endmodule

bind motion_wake_detector mwd_checker i_mwd_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .enable_i      (enable_i),
  .run_i         (run_i),
  .sample_valid_i(sample_valid_i),
  .dir_mask_i    (dir_mask_i),
  .release_i     (release_i),
  .wake_pulse_o  (wake_pulse_o),
  .wake_pending_o(wake_pending_o),
  .dir_status_o  (dir_status_o)
);

// File: tb/test_motion_wake_detector.sv
`timescale 1ns/1ps
module test_motion_wake_detector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable, run, valid, rel;
  logic signed [15:0] xs, ys, zs;
  logic [5:0] mask;
  logic [7:0] thr, cnt;
  logic pulse, pending;
  logic [5:0] status;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  motion_wake_detector i_motion_wake_detector (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .run_i(run),
    .sample_valid_i(valid), .x_i(xs), .y_i(ys), .z_i(zs),
    .dir_mask_i(mask), .thresh_i(thr), .count_i(cnt), .release_i(rel),
    .wake_pulse_o(pulse), .wake_pending_o(pending), .dir_status_o(status)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one strobed sample; outputs registered at the edge in between are checked after return
  task automatic send(input logic signed [15:0] x, input logic signed [15:0] y,
                      input logic signed [15:0] z, input logic r = 1'b0);
    @(negedge clk);
    xs = x; ys = y; zs = z; valid = 1'b1; rel = r;
    @(negedge clk);
    valid = 1'b0; rel = 1'b0;
  endtask

  task automatic quiet();
    send(16'sd0, 16'sd0, 16'sd0);
  endtask

  task automatic do_release();
    @(negedge clk);
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 pulse", pulse, 0);
    check("R1 pending", pending, 0);
    check("R1 status", status, 0);
  endtask

  task automatic t_basic();
    thr = 8'd2; cnt = 8'd3; mask = 6'h3F;
    quiet();
    send(16'sd2048, 0, 0); check("R4 first hit no pulse", pulse, 0);
    send(16'sd2048, 0, 0); check("R4 second hit no pulse", pulse, 0);
    send(16'sd2048, 0, 0); check("R4 third hit pulse", pulse, 1);
    check("R7 status x+", status, 6'b010000);
    check("R8 pending set", pending, 1);
    @(negedge clk); check("R4 pulse one cycle", pulse, 0);
    do_release(); check("R8 release clears", pending, 0);
    check("R7 status held after release", status, 6'b010000);
  endtask

  task automatic t_threshold();
    thr = 8'd2; cnt = 8'd1; mask = 6'h3F;
    quiet();
    send(16'sd2047, 0, 0); check("R2 below positive", pulse, 0);
    send(-16'sd1024, 0, 0); check("R2 -1 quarter g", pulse, 0);
    send(-16'sd1025, 0, 0); check("R2 floor shift negative", pulse, 1);
    check("R2 status x-", status, 6'b100000);
    quiet();
    send(0, 16'sd2048, 0); check("R2 y+ at threshold", pulse, 1);
    check("R2 status y+", status, 6'b000100);
    do_release();
  endtask

  task automatic t_mask();
    thr = 8'd2; cnt = 8'd1; mask = 6'b000010;
    quiet();
    send(0, 0, 16'sd4096); check("R3 z+ masked", pulse, 0);
    send(16'sd4096, -16'sd4096, 0); check("R3 x y masked", pulse, 0);
    send(0, 0, -16'sd4096); check("R3 z- fires", pulse, 1);
    check("R3 status z-", status, 6'b000010);
    mask = 6'b010010;
    quiet();
    send(16'sd4096, 16'sd4096, -16'sd4096); check("R3 two dirs fire", pulse, 1);
    check("R7 status x+ z-", status, 6'b010010);
    do_release();
  endtask

  task automatic t_miss_resets();
    thr = 8'd2; cnt = 8'd3; mask = 6'h3F;
    quiet();
    send(16'sd3000, 0, 0);
    send(16'sd3000, 0, 0);
    send(16'sd100, 0, 0); check("R5 miss no pulse", pulse, 0);
    send(16'sd3000, 0, 0);
    send(16'sd3000, 0, 0); check("R5 count restarted", pulse, 0);
    send(16'sd3000, 0, 0); check("R5 fires after full run", pulse, 1);
    do_release();
  endtask

  task automatic t_idle_gaps();
    thr = 8'd2; cnt = 8'd2; mask = 6'h3F;
    quiet();
    send(0, 0, 16'sd3000); check("R6 first hit", pulse, 0);
    @(negedge clk); xs = 0; ys = 0; zs = 0;
    repeat (5) @(negedge clk);
    check("R6 idle no pulse", pulse, 0);
    send(0, 0, 16'sd3000); check("R6 idle kept count", pulse, 1);
    do_release();
  endtask

  task automatic t_rearm();
    thr = 8'd2; cnt = 8'd0; mask = 6'h3F;
    quiet();
    send(0, 16'sd3000, 0); check("R4 count zero acts as one", pulse, 1);
    send(0, 16'sd3000, 0); check("R9 held motion no refire", pulse, 0);
    send(0, 16'sd3000, 0); check("R9 still no refire", pulse, 0);
    check("R8 pending stays", pending, 1);
    quiet();
    send(0, 16'sd3000, 0); check("R9 refire after miss", pulse, 1);
    do_release();
  endtask

  task automatic t_inactive();
    thr = 8'd2; cnt = 8'd1; mask = 6'h3F;
    quiet();
    enable = 1'b0;
    send(16'sd5000, 0, 0); check("R10 disabled ignored", pulse, 0);
    enable = 1'b1; run = 1'b0;
    send(16'sd5000, 0, 0); check("R10 standby ignored", pulse, 0);
    check("R10 no pending", pending, 0);
    run = 1'b1; cnt = 8'd2;
    send(16'sd5000, 0, 0); check("R10 first hit", pulse, 0);
    @(negedge clk); run = 1'b0;
    @(negedge clk); run = 1'b1;
    send(16'sd5000, 0, 0); check("R10 count cleared by standby", pulse, 0);
    send(16'sd5000, 0, 0); check("R10 fires after new run", pulse, 1);
    do_release();
  endtask

  task automatic t_release_collision();
    thr = 8'd2; cnt = 8'd1; mask = 6'h3F;
    quiet();
    send(0, 0, 16'sd3000); check("R8 setup fire", pending, 1);
    quiet();
    send(0, 0, -16'sd3000, 1'b1); check("R8 fire beats release", pending, 1);
    check("R8 pulse on collision", pulse, 1);
    check("R7 status z-", status, 6'b000010);
    send(0, 0, 0, 1'b1); check("R8 release after", pending, 0);
    check("R7 status held", status, 6'b000010);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    enable = 1'b1; run = 1'b1; valid = 1'b0; rel = 1'b0;
    xs = 0; ys = 0; zs = 0; mask = 6'h3F; thr = 8'd2; cnt = 8'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_threshold();
    t_mask();
    t_miss_resets();
    t_idle_gaps();
    t_rearm();
    t_inactive();
    t_release_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule